// File: doc/BRIEF.md
# Program Counter Sequencer with Branch Target Selection

This block holds the fetch address of a simple in-order core and works out its next value every clock. Each cycle it forms two candidates. One is the sequential address, the current PC plus four. The other is a relative target: an offset field taken from the current instruction word, sign-extended, scaled by four and added to the PC of that same instruction.

The offset comes from one of two fields. The compare-and-branch-on-zero form carries a 19-bit field in instruction bits 23:5. The unconditional branch form carries a 26-bit field in bits 25:0. A single redirect term decides which candidate is loaded. It is the conditional-branch control ANDed with the ALU zero flag, ORed with the unconditional-branch control. For the conditional form, the decoder drives the ALU to pass the tested register straight through, so the zero flag reflects that register's value.

The registered PC goes directly to instruction memory. Indirect jumps, exceptions and prediction are handled elsewhere.

Top module: `fetch_pc_sequencer`

## Requirements
- R1: `rst` is synchronous and active high. One clock edge with `rst` high makes `pc_q` equal to 0, whatever the other inputs are.
- R2: When `cond_br` and `uncond_br` are both low, the next `pc_q` is the current `pc_q` plus 4.
- R3: When `cond_br` and `alu_zero` are high and `uncond_br` is low, the next `pc_q` is the current `pc_q` plus four times the signed 19-bit value in `insn[23:5]`.
- R4: When `cond_br` is high and `alu_zero` is low (with `uncond_br` low), the next `pc_q` is the current `pc_q` plus 4.
- R5: When `uncond_br` is high, the next `pc_q` is the current `pc_q` plus four times the signed 26-bit value in `insn[25:0]`, for any `cond_br` and `alu_zero`.
- R6: When `uncond_br` and `cond_br` are both high, the 26-bit field is used, not the 19-bit field.
- R7: With neither branch control high, the value of `insn` and the value of `alu_zero` have no effect on the next `pc_q`.
- R8: The most negative offsets are handled exactly. A 19-bit field of 0x40000 moves the PC back by 1048576 bytes. A 26-bit field of 0x2000000 moves it back by 134217728 bytes.
- R9: All PC arithmetic wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn | input | 32 | Current instruction word; offset fields at 23:5 and 25:0 |
| cond_br | input | 1 | Conditional branch on zero control |
| uncond_br | input | 1 | Unconditional branch control |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_q | output | 64 | Registered program counter |

## Verification
The PC is the block's only state, so any wrong internal value shows at `pc_q` one edge after the faulty update. Because every later address is computed from that value, the error persists: each following cycle stays offset from the reference model. A wrong redirect decision or a wrong field choice therefore appears in the very next sampled cycle. Sign-extension faults only show for negative offsets, so backward branches and the most negative offsets are driven for both field widths.

// File: rtl/pcsel_pkg.sv
package pcsel_pkg;
    parameter int PC_W = 64;

    typedef logic [PC_W-1:0] pc_t;

    typedef struct packed {
        pc_t pc;
    } pc_state_t;

    typedef enum logic [1:0] {
        SEL_SEQ  = 2'd0,
        SEL_COND = 2'd1,
        SEL_JUMP = 2'd2
    } next_sel_t;
endpackage

// File: rtl/ofs_extend.sv
// Sign-extends an offset field and scales it by 2**SHIFT.
module ofs_extend #(
    parameter int IN_W  = 19,
    parameter int OUT_W = 64,
    parameter int SHIFT = 2
) (
    input  logic [IN_W-1:0]  field,
    output logic [OUT_W-1:0] bytes_out
);
    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        if (i < SHIFT) begin : g_zero
            assign bytes_out[i] = 1'b0;
        end else if (i - SHIFT < IN_W) begin : g_copy
            assign bytes_out[i] = field[i-SHIFT];
        end else begin : g_sign
            assign bytes_out[i] = field[IN_W-1];
        end
    end
endmodule

// File: rtl/pcsel_decide.sv
// Redirect decision: (conditional AND zero) OR unconditional.
module pcsel_decide
    import pcsel_pkg::*;
(
    input  logic      cond_br,
    input  logic      uncond_br,
    input  logic      alu_zero,
    output logic      take,
    output next_sel_t sel
);
    logic cond_hit;

    always_comb begin
        cond_hit = cond_br & alu_zero;
        take     = cond_hit | uncond_br;
        if (uncond_br)     sel = SEL_JUMP;
        else if (cond_hit) sel = SEL_COND;
        else               sel = SEL_SEQ;
    end
endmodule

// File: rtl/pcsel_target.sv
// Forms the relative target and the sequential address, then picks one.
module pcsel_target
    import pcsel_pkg::*;
#(
    parameter int STEP = 4
) (
    input  pc_t       pc,
    input  pc_t       cond_bytes,
    input  pc_t       jump_bytes,
    input  next_sel_t sel,
    input  logic      take,
    output pc_t       next_pc
);
    pc_t seq_pc;
    pc_t offset;
    pc_t target;

    always_comb begin
        seq_pc  = pc + pc_t'(STEP);
        offset  = (sel == SEL_JUMP) ? jump_bytes : cond_bytes;
        target  = pc + offset;
        next_pc = take ? target : seq_pc;
    end
endmodule

// File: rtl/fetch_pc_sequencer.sv
module fetch_pc_sequencer
    import pcsel_pkg::*;
#(
    parameter int INSN_W   = 32,
    parameter int COND_LSB = 5,
    parameter int COND_W   = 19,
    parameter int JUMP_LSB = 0,
    parameter int JUMP_W   = 26,
    parameter int SHIFT    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INSN_W-1:0] insn,
    input  logic              cond_br,
    input  logic              uncond_br,
    input  logic              alu_zero,
    output logic [PC_W-1:0]   pc_q
);
    localparam int COND_MSB = COND_LSB + COND_W - 1;
    localparam int JUMP_MSB = JUMP_LSB + JUMP_W - 1;
    localparam int STEP     = 1 << SHIFT;

    pc_state_t state_d, state_q;
    pc_t       cond_bytes, jump_bytes, next_pc;
    next_sel_t sel;
    logic      take;

    ofs_extend #(.IN_W(COND_W), .OUT_W(PC_W), .SHIFT(SHIFT)) u_cond_ext (
        .field    (insn[COND_MSB:COND_LSB]),
        .bytes_out(cond_bytes)
    );

    ofs_extend #(.IN_W(JUMP_W), .OUT_W(PC_W), .SHIFT(SHIFT)) u_jump_ext (
        .field    (insn[JUMP_MSB:JUMP_LSB]),
        .bytes_out(jump_bytes)
    );

    pcsel_decide u_decide (
        .cond_br  (cond_br),
        .uncond_br(uncond_br),
        .alu_zero (alu_zero),
        .take     (take),
        .sel      (sel)
    );

    pcsel_target #(.STEP(STEP)) u_target (
        .pc        (state_q.pc),
        .cond_bytes(cond_bytes),
        .jump_bytes(jump_bytes),
        .sel       (sel),
        .take      (take),
        .next_pc   (next_pc)
    );

    always_comb begin
        state_d    = state_q;
        state_d.pc = rst ? '0 : next_pc;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign pc_q = state_q.pc;

    // Reference offsets for the checks, built by signed arithmetic
    pc_t cond_ref, jump_ref;
    assign cond_ref = pc_t'($signed(insn[COND_MSB:COND_LSB])) << SHIFT;
    assign jump_ref = pc_t'($signed(insn[JUMP_MSB:JUMP_LSB])) << SHIFT;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (pc_q == '0));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!cond_br && !uncond_br) |=> (pc_q == $past(pc_q) + pc_t'(STEP)));

    assert_cond_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (cond_br && alu_zero && !uncond_br) |=> (pc_q == $past(pc_q) + $past(cond_ref)));

    assert_cond_not_taken_R4: assert property (@(posedge clk) disable iff (rst)
        (cond_br && !alu_zero && !uncond_br) |=> (pc_q == $past(pc_q) + pc_t'(STEP)));

    assert_jump_taken_R5: assert property (@(posedge clk) disable iff (rst)
        uncond_br |=> (pc_q == $past(pc_q) + $past(jump_ref)));
endmodule

// File: tb/fetch_pc_sequencer_test.sv
`timescale 1ns/1ps
module fetch_pc_sequencer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] insn = '0;
    logic        cond_br = 1'b0;
    logic        uncond_br = 1'b0;
    logic        alu_zero = 1'b0;
    logic [63:0] pc_q;

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [63:0] exp_pc = '0;

    always #2 clk = ~clk;

    fetch_pc_sequencer uut (
        .clk(clk), .rst(rst), .insn(insn), .cond_br(cond_br),
        .uncond_br(uncond_br), .alu_zero(alu_zero), .pc_q(pc_q)
    );

    function automatic logic [31:0] cond_word(input logic [18:0] o);
        return {8'h5A, o, 5'd7};
    endfunction

    function automatic logic [31:0] jump_word(input logic [25:0] o);
        return {6'b000101, o};
    endfunction

    task automatic check(input logic [63:0] got, input logic [63:0] want, input string tag);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    // Drives one cycle, advances the model, samples at the following negedge
    task automatic step(input logic c, input logic u, input logic z,
                        input logic [31:0] word, input string tag);
        longint      off;
        logic [63:0] nxt;
        cond_br = c; uncond_br = u; alu_zero = z; insn = word;
        if ((c && z) || u) begin
            if (u) off = longint'($signed(word[25:0]));
            else   off = longint'($signed(word[23:5]));
            nxt = exp_pc + 64'(off * 4);
        end else begin
            nxt = exp_pc + 64'd4;
        end
        @(posedge clk);
        @(negedge clk);
        check(pc_q, nxt, tag);
        exp_pc = nxt;
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1; cond_br = 1'b1; uncond_br = 1'b1; alu_zero = 1'b1;
        insn = jump_word(26'h0001234);
        @(posedge clk);
        @(negedge clk);
        check(pc_q, 64'd0, tag);
        rst = 1'b0;
        exp_pc = '0;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        @(negedge clk);
        do_reset("R1 reset with branch inputs active");
        step(0, 0, 0, 32'h0, "R2 sequential 1");
        step(0, 0, 0, 32'h0, "R2 sequential 2");
        step(0, 0, 1, 32'hFFFF_FFFF, "R7 zero high, all-ones word ignored");
        step(0, 0, 0, 32'hA5C3_0F96, "R7 arbitrary word ignored");
        step(1, 0, 1, cond_word(19'd10), "R3 forward conditional");
        step(1, 0, 1, cond_word(-19'sd3), "R3 backward conditional");
        step(1, 0, 0, cond_word(19'd500), "R4 conditional not taken");
        step(1, 0, 1, cond_word(19'h3FFFF), "R3 conditional offset -1");
        step(1, 0, 1, cond_word(19'h1FFFF), "R3 largest positive conditional");
        step(1, 0, 1, cond_word(19'h40000), "R8 most negative conditional");
        step(0, 1, 0, jump_word(26'd1000), "R5 forward jump");
        step(0, 1, 1, jump_word(-26'sd77), "R5 backward jump with zero high");
        step(0, 1, 0, jump_word(26'h2000000), "R8 most negative jump");
        step(1, 1, 1, {6'b0, 2'b01, 19'h00040, 5'd0}, "R6 both controls use 26-bit field");
        step(1, 1, 0, jump_word(26'h3FFFFF0), "R5 jump with cond set, zero low");
        step(0, 0, 1, cond_word(19'h40000), "R7 offset present but no branch");
        do_reset("R1 reset mid-run");
        step(0, 1, 0, jump_word(26'h3FFFFFF), "R9 wrap below zero");
        step(0, 0, 0, 32'h0, "R9 wrap back to zero");
        step(0, 0, 0, 32'h0, "R2 sequential after wrap");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule